// File: doc/BRIEF.md
# Read-After-Write Hazard Interlock

This block decides, every cycle, whether the instruction sitting in the decode latch of a five-stage in-order integer pipeline may move on. The pipeline has no bypass paths, so an instruction that reads a register must wait until every older instruction that writes that register has finished write-back. The block looks at the two source register numbers of the decoding instruction. It compares each of them with the destination register of each of the three older instructions, which sit in the execute, memory and write-back latches.

Each older latch hands over four things: its write enable, its destination-select bit, and both of its candidate destination fields. The destination-select bit picks which of the two fields is the real destination. When any live destination matches a source, the block does three things in the same cycle: it freezes the program counter, it freezes the fetch/decode latch, and it forces the control word entering execute to all zeros. The execute latch therefore receives a no-op bubble. The block is purely combinational, and its outputs follow its inputs within the same cycle.

Top module: `raw_interlock`

## Requirements
- R1: When no older stage has its write enable set, the outputs are pc_write_en=1, ifid_write_en=1 and ctrl_zero=0.
- R2: When the execute-stage destination-select bit is 0, the execute-stage destination is its first field (stg_rt_fld bits 4:0). A stall occurs if that field equals dec_rs or dec_rt, and the second field is then ignored.
- R3: When the execute-stage destination-select bit is 1, the execute-stage destination is its second field (stg_rd_fld bits 4:0). A stall occurs if that field equals dec_rs or dec_rt, and the first field is then ignored.
- R4: A write-enabled memory-stage entry (index 1, field bits 9:5) whose selected destination equals either source causes a stall.
- R5: A write-enabled write-back-stage entry (index 2, field bits 14:10) whose selected destination equals either source causes a stall.
- R6: An older stage whose write enable is 0 never causes a stall, even when its fields match a source. This covers stores and branches.
- R7: A selected destination of register 0 never causes a stall.
- R8: pc_write_en and ifid_write_en are always equal, and ctrl_zero is always their inverse.
- R9: In a latch pipeline driven by these outputs, a writer followed directly by a reader of its destination produces exactly three bubble cycles, after which the reader enters execute. Independent back-to-back instructions produce no bubble.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| dec_rs | input | 5 | First source register number of the decoding instruction |
| dec_rt | input | 5 | Second source register number of the decoding instruction |
| stg_wr_en | input | 3 | Write enable per older stage (bit 0 execute, 1 memory, 2 write-back) |
| stg_dst_sel | input | 3 | Destination-select per older stage: 0 picks the first field, 1 the second |
| stg_rt_fld | input | 15 | First candidate destination field per stage, 5 bits each, stage k at bits 5k+4:5k |
| stg_rd_fld | input | 15 | Second candidate destination field per stage, same packing |
| pc_write_en | output | 1 | 1 lets the program counter update this cycle |
| ifid_write_en | output | 1 | 1 lets the fetch/decode latch load this cycle |
| ctrl_zero | output | 1 | 1 forces the control word entering execute to zero (bubble) |

## Verification
The checks assume the latch inputs describe a real pipeline: each stage carries one coherent entry, and a stage holding a bubble presents a write enable of 0. Because the block holds no state, the checks are evaluated only once every input is a known value.

The directed stimulus sets one older stage at a time against chosen source numbers, so that each stall can be traced to a single stage. A small bench-side latch pipeline always drives bubbles with a cleared write enable. It feeds the block's own outputs back into the latches to reproduce the three-bubble sequence.

// File: rtl/raw_pkg.sv
// Package raw_pkg
// Purpose : default sizes and the destination-select encoding shared by the
//           hazard interlock and its checker.
// Assumes : register numbers are unsigned and register 0 is hardwired zero.
package raw_pkg;
    localparam int RAW_REG_W   = 5;
    localparam int RAW_NUM_STG = 3;

    typedef enum logic {
        DST_FROM_RT = 1'b0,
        DST_FROM_RD = 1'b1
    } dst_src_e;
endpackage

// File: rtl/raw_dst_mux.sv
// Module raw_dst_mux
// Purpose : picks the real destination of one older latch from its two
//           candidate fields and marks it live when it will be written.
// Assumes : a bubble in the latch arrives with wr_en cleared.
module raw_dst_mux
    import raw_pkg::*;
#(
    parameter int REG_W = RAW_REG_W
) (
    input  logic             wr_en,
    input  logic             dst_sel,
    input  logic [REG_W-1:0] rt_fld,
    input  logic [REG_W-1:0] rd_fld,
    output logic [REG_W-1:0] dst_num,
    output logic             dst_live
);
    dst_src_e sel_e;

    // decode the select bit and choose the destination field
    always_comb begin
        sel_e   = dst_src_e'(dst_sel);
        dst_num = (sel_e == DST_FROM_RD) ? rd_fld : rt_fld;
    end

    // a destination counts only when written and not the zero register
    always_comb begin
        dst_live = wr_en && (dst_num != '0);
    end
endmodule

// File: rtl/raw_src_cmp.sv
// Module raw_src_cmp
// Purpose : flags a hazard when a live destination equals either source
//           register of the decoding instruction.
// Assumes : dst_live already excludes register 0 and disabled writes.
module raw_src_cmp
    import raw_pkg::*;
#(
    parameter int REG_W = RAW_REG_W
) (
    input  logic [REG_W-1:0] dst_num,
    input  logic             dst_live,
    input  logic [REG_W-1:0] src_a,
    input  logic [REG_W-1:0] src_b,
    output logic             hit
);
    logic match_a;
    logic match_b;

    // equality against each source operand
    always_comb begin
        match_a = (dst_num == src_a);
        match_b = (dst_num == src_b);
    end

    // qualify with liveness
    always_comb begin
        hit = dst_live && (match_a || match_b);
    end
endmodule

// File: rtl/raw_stall_ctl.sv
// Module raw_stall_ctl
// Purpose : folds per-stage hazard flags into the freeze and bubble controls.
// Assumes : any single flag is enough to stall the front of the pipeline.
module raw_stall_ctl #(
    parameter int NUM_STG = 3
) (
    input  logic [NUM_STG-1:0] hit_vec,
    output logic               pc_write_en,
    output logic               ifid_write_en,
    output logic               ctrl_zero
);
    logic stall;

    // reduce the flags to one stall decision
    always_comb begin
        stall = |hit_vec;
    end

    // drive freeze enables and bubble request from the decision
    always_comb begin
        pc_write_en   = !stall;
        ifid_write_en = !stall;
        ctrl_zero     = stall;
    end
endmodule

// File: rtl/raw_interlock.sv
// Module raw_interlock
// Purpose : read-after-write interlock for a five-stage pipeline without
//           bypassing; stalls decode while any older writer targets one of
//           its sources.
// Assumes : stage 0 is execute, 1 memory, 2 write-back; fields are packed
//           REG_W bits per stage, lowest stage in the lowest bits. Purely
//           combinational, so it needs no clock or reset.
module raw_interlock
    import raw_pkg::*;
#(
    parameter int REG_W   = RAW_REG_W,
    parameter int NUM_STG = RAW_NUM_STG
) (
    input  logic [REG_W-1:0]         dec_rs,
    input  logic [REG_W-1:0]         dec_rt,
    input  logic [NUM_STG-1:0]       stg_wr_en,
    input  logic [NUM_STG-1:0]       stg_dst_sel,
    input  logic [NUM_STG*REG_W-1:0] stg_rt_fld,
    input  logic [NUM_STG*REG_W-1:0] stg_rd_fld,
    output logic                     pc_write_en,
    output logic                     ifid_write_en,
    output logic                     ctrl_zero
);
    localparam int FLD_W = NUM_STG * REG_W;

    logic [FLD_W-1:0]   stg_dst;
    logic [NUM_STG-1:0] stg_live;
    logic [NUM_STG-1:0] stg_hit;

    // one destination picker and one comparator per older stage
    for (genvar k = 0; k < NUM_STG; k++) begin : g_stage
        raw_dst_mux #(.REG_W(REG_W)) u_dst (
            .wr_en   (stg_wr_en[k]),
            .dst_sel (stg_dst_sel[k]),
            .rt_fld  (stg_rt_fld[k*REG_W +: REG_W]),
            .rd_fld  (stg_rd_fld[k*REG_W +: REG_W]),
            .dst_num (stg_dst[k*REG_W +: REG_W]),
            .dst_live(stg_live[k])
        );

        raw_src_cmp #(.REG_W(REG_W)) u_cmp (
            .dst_num (stg_dst[k*REG_W +: REG_W]),
            .dst_live(stg_live[k]),
            .src_a   (dec_rs),
            .src_b   (dec_rt),
            .hit     (stg_hit[k])
        );
    end

    raw_stall_ctl #(.NUM_STG(NUM_STG)) u_ctl (
        .hit_vec      (stg_hit),
        .pc_write_en  (pc_write_en),
        .ifid_write_en(ifid_write_en),
        .ctrl_zero    (ctrl_zero)
    );
endmodule

// File: rtl/raw_interlock_chk.sv
// Module raw_interlock_chk
// Purpose : immediate checks on the interlock, bound to raw_interlock.
// Assumes : checks are skipped while any observed input is unknown.
module raw_interlock_chk #(
    parameter int REG_W   = 5,
    parameter int NUM_STG = 3
) (
    input logic [REG_W-1:0]         dec_rs,
    input logic [REG_W-1:0]         dec_rt,
    input logic [NUM_STG-1:0]       stg_wr_en,
    input logic [NUM_STG-1:0]       stg_dst_sel,
    input logic [NUM_STG*REG_W-1:0] stg_rt_fld,
    input logic [NUM_STG*REG_W-1:0] stg_rd_fld,
    input logic [NUM_STG-1:0]       stg_hit,
    input logic                     pc_write_en,
    input logic                     ifid_write_en,
    input logic                     ctrl_zero
);
    logic known;

    // gate all checks on fully known inputs and outputs
    always_comb begin
        known = !$isunknown({dec_rs, dec_rt, stg_wr_en, stg_dst_sel,
                             stg_rt_fld, stg_rd_fld, stg_hit,
                             pc_write_en, ifid_write_en, ctrl_zero});
    end

    // top-level output relations
    always_comb begin
        if (known) begin
            p_quiet_r1: assert (stg_wr_en != '0 || pc_write_en)
                else $error("R1: stall with no writer");
            p_pair_r8: assert (pc_write_en == ifid_write_en)
                else $error("R8: freeze enables differ");
            p_bubble_r8: assert (ctrl_zero == !pc_write_en)
                else $error("R8: bubble not tied to freeze");
            p_zero_src_r7: assert (dec_rs != '0 || dec_rt != '0 || pc_write_en)
                else $error("R7: stall on register 0");
            p_hit_stall_r4: assert ((stg_hit != '0) == !pc_write_en)
                else $error("R4: stage hit not reflected at outputs");
        end
    end

    // per-stage relations
    for (genvar k = 0; k < NUM_STG; k++) begin : g_chk
        always_comb begin
            if (known) begin
                p_no_we_r6: assert (stg_wr_en[k] || !stg_hit[k])
                    else $error("R6: hit from a non-writing stage");
                p_sel_rd_r3: assert (!(stg_dst_sel[k] &&
                                       stg_rd_fld[k*REG_W +: REG_W] == '0) ||
                                     !stg_hit[k])
                    else $error("R3: hit on zero second field");
            end
        end
    end
endmodule

bind raw_interlock raw_interlock_chk #(.REG_W(REG_W), .NUM_STG(NUM_STG)) u_chk (
    .dec_rs       (dec_rs),
    .dec_rt       (dec_rt),
    .stg_wr_en    (stg_wr_en),
    .stg_dst_sel  (stg_dst_sel),
    .stg_rt_fld   (stg_rt_fld),
    .stg_rd_fld   (stg_rd_fld),
    .stg_hit      (stg_hit),
    .pc_write_en  (pc_write_en),
    .ifid_write_en(ifid_write_en),
    .ctrl_zero    (ctrl_zero)
);

// File: tb/raw_interlock_bench.sv
// Directed bench for raw_interlock; each scenario task checks its own results.
module raw_interlock_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  dec_rs, dec_rt;
    logic [2:0]  stg_wr_en, stg_dst_sel;
    logic [14:0] stg_rt_fld, stg_rd_fld;
    logic        pc_write_en, ifid_write_en, ctrl_zero;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    typedef struct packed {
        logic       we;
        logic       sel;
        logic [4:0] rs;
        logic [4:0] rt;
        logic [4:0] rd;
    } ins_t;

    localparam ins_t NOP = '0;

    always #10 clk = !clk;  // 50 MHz

    raw_interlock u_raw_interlock (
        .dec_rs(dec_rs), .dec_rt(dec_rt),
        .stg_wr_en(stg_wr_en), .stg_dst_sel(stg_dst_sel),
        .stg_rt_fld(stg_rt_fld), .stg_rd_fld(stg_rd_fld),
        .pc_write_en(pc_write_en), .ifid_write_en(ifid_write_en),
        .ctrl_zero(ctrl_zero)
    );

    task automatic clear_all();
        dec_rs = '0; dec_rt = '0;
        stg_wr_en = '0; stg_dst_sel = '0;
        stg_rt_fld = '0; stg_rd_fld = '0;
    endtask

    task automatic set_stage(int k, ins_t e);
        stg_wr_en[k]            = e.we;
        stg_dst_sel[k]          = e.sel;
        stg_rt_fld[k*5 +: 5]    = e.rt;
        stg_rd_fld[k*5 +: 5]    = e.rd;
    endtask

    // compare all three outputs against the expected stall decision
    task automatic expect_out(bit stall, string req);
        #1;
        n_cmp++;
        if (pc_write_en !== !stall || ifid_write_en !== !stall || ctrl_zero !== stall) begin
            n_bad++;
            $display("FAIL %s: pc=%b ifid=%b zero=%b expected pc=%b ifid=%b zero=%b",
                     req, pc_write_en, ifid_write_en, ctrl_zero, !stall, !stall, stall);
        end
    endtask

    task automatic t_reset();
        @(negedge clk); clear_all();
        expect_out(1'b0, "R1 idle after reset");
        set_stage(0, '{we:0, sel:1, rs:0, rt:6, rd:6});
        dec_rs = 5'd6;
        expect_out(1'b0, "R1 no writer enabled");
    endtask

    task automatic t_idex_rt();
        @(negedge clk); clear_all();
        set_stage(0, '{we:1, sel:0, rs:0, rt:7, rd:9});
        dec_rs = 5'd7; expect_out(1'b1, "R2 first field vs rs");
        dec_rs = 5'd1; dec_rt = 5'd7; expect_out(1'b1, "R2 first field vs rt");
        dec_rs = 5'd9; dec_rt = 5'd3; expect_out(1'b0, "R2 second field ignored");
    endtask

    task automatic t_idex_rd();
        @(negedge clk); clear_all();
        set_stage(0, '{we:1, sel:1, rs:0, rt:7, rd:9});
        dec_rs = 5'd9; expect_out(1'b1, "R3 second field vs rs");
        dec_rs = 5'd7; dec_rt = 5'd7; expect_out(1'b0, "R3 first field ignored");
    endtask

    task automatic t_exmem();
        @(negedge clk); clear_all();
        set_stage(1, '{we:1, sel:1, rs:0, rt:2, rd:4});
        dec_rt = 5'd4; expect_out(1'b1, "R4 memory stage match");
        dec_rt = 5'd2; expect_out(1'b0, "R4 memory stage other field");
    endtask

    task automatic t_memwb();
        @(negedge clk); clear_all();
        set_stage(2, '{we:1, sel:0, rs:0, rt:31, rd:8});
        dec_rs = 5'd31; expect_out(1'b1, "R5 write-back stage match");
        dec_rs = 5'd30; expect_out(1'b0, "R5 write-back no match");
    endtask

    task automatic t_no_we();
        for (int k = 0; k < 3; k++) begin
            @(negedge clk); clear_all();
            set_stage(k, '{we:0, sel:1, rs:0, rt:12, rd:12});
            dec_rs = 5'd12; dec_rt = 5'd12;
            expect_out(1'b0, "R6 store/branch stage ignored");
        end
    endtask

    task automatic t_zero();
        for (int k = 0; k < 3; k++) begin
            @(negedge clk); clear_all();
            set_stage(k, '{we:1, sel:1, rs:0, rt:5, rd:0});
            dec_rs = 5'd0; dec_rt = 5'd0;
            expect_out(1'b0, "R7 register zero never stalls");
        end
    endtask

    // latch pipeline driven by the block's own freeze/bubble outputs
    task automatic run_pair(ins_t prod, ins_t cons, int exp_stalls, string req);
        ins_t ifid, idex, exmem, memwb, fetch_q;
        int   stalls = 0;
        bit   issued = 1'b0;
        ifid = prod; idex = NOP; exmem = NOP; memwb = NOP; fetch_q = cons;
        for (int cyc = 0; cyc < 8; cyc++) begin
            @(negedge clk);
            dec_rs = ifid.rs; dec_rt = ifid.rt;
            set_stage(0, idex); set_stage(1, exmem); set_stage(2, memwb);
            #1;
            // R8: freeze and bubble controls move together
            if (pc_write_en !== ifid_write_en || ctrl_zero !== !pc_write_en) begin
                n_bad++;
                $display("FAIL R8: pc=%b ifid=%b zero=%b expected coherent",
                         pc_write_en, ifid_write_en, ctrl_zero);
            end
            memwb = exmem; exmem = idex;
            if (ctrl_zero) begin
                stalls++;
                idex = NOP;
            end else begin
                if (ifid == cons && cyc > 0) issued = 1'b1;
                idex = ifid; ifid = fetch_q; fetch_q = NOP;
            end
        end
        n_cmp++;
        if (stalls != exp_stalls || !issued) begin
            n_bad++;
            $display("FAIL %s: bubbles=%0d issued=%0d expected bubbles=%0d issued=1",
                     req, stalls, issued, exp_stalls);
        end
    endtask

    task automatic t_sequence();
        run_pair('{we:1, sel:1, rs:1, rt:3, rd:2}, '{we:1, sel:1, rs:2, rt:5, rd:12},
                 3, "R9 dependent pair via second field");
        run_pair('{we:1, sel:0, rs:1, rt:6, rd:0}, '{we:0, sel:0, rs:4, rt:6, rd:0},
                 3, "R9 dependent pair via first field");
        run_pair('{we:1, sel:1, rs:1, rt:3, rd:10}, '{we:1, sel:1, rs:2, rt:5, rd:11},
                 0, "R9 independent pair");
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        clear_all();
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        t_reset();
        t_idex_rt();
        t_idex_rd();
        t_exmem();
        t_memwb();
        t_no_we();
        t_zero();
        t_sequence();
        done = 1'b1;
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: run incomplete, expected completion");
            finish_run();
        end
    end
endmodule